// File: doc/BRIEF.md
# Dual-Enable Tristate Byte Driver

This block carries two independent 9-bit bytes, A and B, from input pins to output pins. Each byte is gated by its own pair of active-low enables, and a byte drives only when both of its enables are low. A high-impedance output is modelled as a data vector plus a per-byte drive flag. While the flag is low the data vector reads as zero. All outputs are registered, so every result appears one clock after the inputs that cause it.

After reset a byte stays undriven until its enable condition has been seen inactive in at least one cycle. An enable that is already active when reset ends therefore does not turn the byte on; the pins must make an inactive-to-active transition first. A test-mode port lets a scan wrapper supply the data and the active-high drive value for each byte, bypassing the pins and the arming gate.

Top module: `bytedrv_top`

## Requirements
- R1: One cycle after a clock edge sampled with `rst` high, `a_drive` and `b_drive` are 0 and `a_out` and `b_out` are all zeros.
- R2: In normal mode (`tst_mode`=0), an armed byte drives in the cycle after both of its enables (`x_oe1_n`, `x_oe2_n`) are sampled low.
- R3: In normal mode, if either enable of a byte is sampled high, that byte's drive flag is 0 in the next cycle and its data output is all zeros, whatever its data input holds.
- R4: While a byte drives from its pins, its output equals the data input sampled at the previous edge, with no inversion.
- R5: After reset, a byte whose enable pair has been active in every cycle since reset does not drive, even though both enables are low.
- R6: Once a byte has been armed (its enable pair was sampled inactive at least once since reset), it stays armed until the next reset.
- R7: The two bytes are independent: arming, enabling and data on one byte have no effect on the other's outputs.
- R8: With `tst_mode`=1, each byte's drive flag in the next cycle equals its `tst_x_drive` input and, when that is 1, its data equals `tst_x_data`; pins and arming state are ignored.
- R9: Arming keeps following the enable pins while `tst_mode`=1, so a byte whose pins went inactive during test mode drives from its pins once test mode ends, and one whose pins stayed active does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 9 | Byte A data input |
| a_oe1_n | input | 1 | Byte A enable 1, active low |
| a_oe2_n | input | 1 | Byte A enable 2, active low |
| b_in | input | 9 | Byte B data input |
| b_oe1_n | input | 1 | Byte B enable 1, active low |
| b_oe2_n | input | 1 | Byte B enable 2, active low |
| tst_mode | input | 1 | Test override select |
| tst_a_data | input | 9 | Override data for byte A |
| tst_a_drive | input | 1 | Override drive for byte A, active high |
| tst_b_data | input | 9 | Override data for byte B |
| tst_b_drive | input | 1 | Override drive for byte B, active high |
| a_out | output | 9 | Byte A data output, zero when not driven |
| a_drive | output | 1 | Byte A drive flag (0 = high impedance) |
| b_out | output | 9 | Byte B data output, zero when not driven |
| b_drive | output | 1 | Byte B drive flag (0 = high impedance) |

## Verification
A wrong arming flag shows at the ports as a byte that drives right after reset with its enables held low, or one that never drives after a clean inactive-to-active transition. Either shows in the first cycle the enable pair is active. A fault in the source selection or lane mux shows one cycle after the offending input as a drive flag or data word that differs from the reference model. Random stimulus switches the enables and test mode often, so arming is exercised both before and after many resets.

// File: rtl/bytedrv_pkg.sv
package bytedrv_pkg;
  typedef enum logic {SRC_PIN = 1'b0, SRC_TEST = 1'b1} drv_src_e;

  // both active-low enables low -> request to drive
  function automatic logic pair_active(input logic e1_n, input logic e2_n);
    return ~(e1_n | e2_n);
  endfunction
endpackage

// File: rtl/bytedrv_arm.sv
module bytedrv_arm (
  input  logic clk,
  input  logic rst,
  input  logic oe1_n,
  input  logic oe2_n,
  output logic pin_act,
  output logic armed
);
  import bytedrv_pkg::*;

  assign pin_act = pair_active(oe1_n, oe2_n);

  // armed sets once the enable pair is seen inactive; cleared only by reset
  always_ff @(posedge clk) begin
    if (rst)           armed <= 1'b0;
    else if (!pin_act) armed <= 1'b1;
  end
endmodule

// File: rtl/bytedrv_lane.sv
module bytedrv_lane #(
  parameter int BYTE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] pin_data,
  input  logic              pin_act,
  input  logic              armed,
  input  logic              tst_mode,
  input  logic [BYTE_W-1:0] tst_data,
  input  logic              tst_drive,
  output logic [BYTE_W-1:0] out_q,
  output logic              drive_q
);
  import bytedrv_pkg::*;

  drv_src_e          src;
  logic              drive_d;
  logic [BYTE_W-1:0] data_d;

  always_comb begin
    src     = tst_mode ? SRC_TEST : SRC_PIN;
    drive_d = 1'b0;
    data_d  = '0;
    case (src)
      SRC_TEST: begin
        drive_d = tst_drive;
        data_d  = tst_data;
      end
      default: begin
        drive_d = armed & pin_act;
        data_d  = pin_data;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      out_q   <= '0;
    end else begin
      drive_q <= drive_d;
      out_q   <= drive_d ? data_d : '0;
    end
  end
endmodule

// File: rtl/bytedrv_top.sv
module bytedrv_top #(
  parameter int BYTE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] a_in,
  input  logic              a_oe1_n,
  input  logic              a_oe2_n,
  input  logic [BYTE_W-1:0] b_in,
  input  logic              b_oe1_n,
  input  logic              b_oe2_n,
  input  logic              tst_mode,
  input  logic [BYTE_W-1:0] tst_a_data,
  input  logic              tst_a_drive,
  input  logic [BYTE_W-1:0] tst_b_data,
  input  logic              tst_b_drive,
  output logic [BYTE_W-1:0] a_out,
  output logic              a_drive,
  output logic [BYTE_W-1:0] b_out,
  output logic              b_drive
);
  localparam int LANES = 2;

  logic [LANES-1:0][BYTE_W-1:0] in_v, tdat_v, out_v;
  logic [LANES-1:0]             e1_v, e2_v, tdrv_v, act_v, arm_v, drv_v;

  assign in_v   = {b_in, a_in};
  assign e1_v   = {b_oe1_n, a_oe1_n};
  assign e2_v   = {b_oe2_n, a_oe2_n};
  assign tdat_v = {tst_b_data, tst_a_data};
  assign tdrv_v = {tst_b_drive, tst_a_drive};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bytedrv_arm u_arm (
      .clk(clk), .rst(rst), .oe1_n(e1_v[g]), .oe2_n(e2_v[g]),
      .pin_act(act_v[g]), .armed(arm_v[g])
    );
    bytedrv_lane #(.BYTE_W(BYTE_W)) u_lane (
      .clk(clk), .rst(rst), .pin_data(in_v[g]), .pin_act(act_v[g]),
      .armed(arm_v[g]), .tst_mode(tst_mode), .tst_data(tdat_v[g]),
      .tst_drive(tdrv_v[g]), .out_q(out_v[g]), .drive_q(drv_v[g])
    );
  end

  assign a_out   = out_v[0];
  assign b_out   = out_v[1];
  assign a_drive = drv_v[0];
  assign b_drive = drv_v[1];
endmodule

// File: rtl/bytedrv_chk.sv
module bytedrv_chk #(
  parameter int BYTE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] a_in,
  input logic              a_oe1_n,
  input logic              a_oe2_n,
  input logic              tst_mode,
  input logic [BYTE_W-1:0] tst_a_data,
  input logic              tst_a_drive,
  input logic [BYTE_W-1:0] a_out,
  input logic              a_drive,
  input logic              b_drive
);
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(tst_mode)) |-> (!a_drive && !b_drive)); // R1

  AST_EN_HIGH_OFF: assert property (@(posedge clk) disable iff (rst)
    (!tst_mode && (a_oe1_n || a_oe2_n)) |=> !a_drive); // R3

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !a_drive |-> (a_out == '0)); // R3

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    (a_drive && !$past(rst) && !$past(tst_mode)) |-> (a_out == $past(a_in))); // R4

  AST_OVR_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tst_mode)) |-> (a_drive == $past(tst_a_drive))); // R8

  AST_OVR_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tst_mode) && a_drive) |-> (a_out == $past(tst_a_data))); // R8
endmodule

bind bytedrv_top bytedrv_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .a_oe1_n(a_oe1_n), .a_oe2_n(a_oe2_n),
  .tst_mode(tst_mode), .tst_a_data(tst_a_data), .tst_a_drive(tst_a_drive),
  .a_out(a_out), .a_drive(a_drive), .b_drive(b_drive)
);

// File: tb/tb_bytedrv_top.sv
module tb_bytedrv_top;
  localparam int W = 9;
  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b_in, tst_a_data, tst_b_data;
  logic a_oe1_n, a_oe2_n, b_oe1_n, b_oe2_n, tst_mode, tst_a_drive, tst_b_drive;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;

  int checks = 0, fails = 0;
  // reference model state
  logic m_arm [2];
  logic m_drv [2];
  logic [W-1:0] m_out [2];

  always #4 clk = ~clk;

  bytedrv_top #(.BYTE_W(W)) dut (.*);

  function automatic logic act(input logic e1, input logic e2);
    return !e1 && !e2;
  endfunction

  function automatic logic [W-1:0] next_out(input logic d, input logic [W-1:0] v);
    return d ? v : '0;
  endfunction

  task automatic model_edge();
    logic ac [2];
    logic [W-1:0] di [2], td [2];
    logic tdr [2];
    ac[0] = act(a_oe1_n, a_oe2_n); ac[1] = act(b_oe1_n, b_oe2_n);
    di[0] = a_in; di[1] = b_in; td[0] = tst_a_data; td[1] = tst_b_data;
    tdr[0] = tst_a_drive; tdr[1] = tst_b_drive;
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_arm[i] = 1'b0; m_drv[i] = 1'b0; m_out[i] = '0;
      end else begin
        m_drv[i] = tst_mode ? tdr[i] : (m_arm[i] && ac[i]);
        m_out[i] = next_out(m_drv[i], tst_mode ? td[i] : di[i]);
        if (!ac[i]) m_arm[i] = 1'b1;
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, {31'b0, a_drive}, {31'b0, m_drv[0]});
    chk(req, {23'b0, a_out},   {23'b0, m_out[0]});
    chk(req, {31'b0, b_drive}, {31'b0, m_drv[1]});
    chk(req, {23'b0, b_out},   {23'b0, m_out[1]});
  endtask

  // apply inputs at negedge, model at posedge, sample 1 ns later
  task automatic step(input string req);
    @(posedge clk);
    model_edge();
    #1;
    chk_all(req);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    rst = 1; tst_mode = 0; tst_a_drive = 0; tst_b_drive = 0;
    tst_a_data = '0; tst_b_data = '0;
    a_in = 9'h1A5; b_in = 9'h0F3;
    a_oe1_n = 0; a_oe2_n = 0; b_oe1_n = 0; b_oe2_n = 0;
    @(negedge clk);
    step("R1"); step("R1");
    chk("R1", {31'b0, a_drive | b_drive}, 32'd0);
    rst = 0;
    // enables held active since reset: no drive
    for (int i = 0; i < 5; i++) step("R5");
    chk("R5", {31'b0, a_drive}, 32'd0);
    // A goes inactive one cycle, B stays active
    a_oe1_n = 1; step("R3");
    a_oe1_n = 0; a_in = 9'h155; step("R2");
    chk("R2", {31'b0, a_drive}, 32'd1);
    chk("R4", {23'b0, a_out}, 32'h155);
    chk("R7", {31'b0, b_drive}, 32'd0);
    // either enable high, random data ignored
    a_oe2_n = 1; a_in = 9'h1FF; step("R3");
    chk("R3", {23'b0, a_out}, 32'd0);
    a_oe2_n = 0; a_in = 9'h0AA; step("R6");
    chk("R6", {31'b0, a_drive}, 32'd1);
    // override while B unarmed
    tst_mode = 1; tst_b_drive = 1; tst_b_data = 9'h123; tst_a_drive = 0;
    step("R8");
    chk("R8", {23'b0, b_out}, 32'h123);
    chk("R8", {31'b0, a_drive}, 32'd0);
    tst_mode = 0; step("R9");
    chk("R9", {31'b0, b_drive}, 32'd0);
    // B goes inactive during override, then drives after exit
    tst_mode = 1; b_oe2_n = 1; step("R9");
    b_oe2_n = 0; step("R9");
    tst_mode = 0; b_in = 9'h0C3; step("R9");
    chk("R9", {31'b0, b_drive}, 32'd1);
    chk("R7", {23'b0, b_out}, 32'h0C3);
    // random phase with occasional reset
    for (int n = 0; n < 3000; n++) begin
      rst = ($urandom_range(0, 99) == 0);
      a_in = W'($urandom); b_in = W'($urandom);
      tst_a_data = W'($urandom); tst_b_data = W'($urandom);
      a_oe1_n = ($urandom_range(0, 3) == 0); a_oe2_n = ($urandom_range(0, 3) == 0);
      b_oe1_n = ($urandom_range(0, 3) == 0); b_oe2_n = ($urandom_range(0, 3) == 0);
      tst_mode = ($urandom_range(0, 7) == 0);
      tst_a_drive = 1'($urandom); tst_b_drive = 1'($urandom);
      if (rst) step("R1");
      else if (tst_mode) step("R8");
      else step("R2_R3_R4_R7");
    end
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule